// File: doc/BRIEF.md
# Completion Lower-Address Rebuilder

This block sits on the requester side of a PCIe-style link and restores a full 12-bit lower byte address for every returning read completion. A standard completion header carries only 7 address bits. That is not enough to tell where a completion belongs inside a 4 KiB region once a request has been split into several completions.

To recover the missing bits, the block keeps one slot for each outstanding non-posted read. The slot is indexed by the request tag. It holds the low 12 bits of the request's byte address and the number of bytes still owed. When a request is issued, its slot is filled. When a completion beat arrives, the block looks up its tag and forms the result from two parts: the upper 5 bits come from the slot and the lower 7 bits come from the header. After a successful partial completion, the slot's address moves forward by the bytes delivered. The slot is released when nothing more is owed or when a completion reports an error.

The result is registered, carries the completion's error status, and is accompanied by three sticky protocol flags.

Top module: `cpl_la_rebuild`

## Requirements
- R1: While reset is high and on the first cycle after it, `res_valid` is 0, all three flags are 0, and every slot is empty. A completion on any tag after reset therefore counts as unexpected.
- R2: A completion whose tag has an occupied slot produces `res_valid`=1 exactly one clock after it is sampled. `res_tag` equals the completion tag.
- R3: For a successful completion (`cpl_err`=0), `res_addr[6:0]` equals `cpl_lo_addr`, `res_addr[11:7]` equals bits [11:7] of the slot's current byte address, and `res_hi_ok`=1.
- R4: For an error completion (`cpl_err`=1), `res_addr[11:7]` is 0, `res_addr[6:0]` equals `cpl_lo_addr`, `res_hi_ok`=0, `res_err`=1 and `res_last`=1. The slot is released.
- R5: After a successful completion that leaves bytes owed, the slot address advances by `cpl_bytes`, wrapping modulo 4096. The owed count falls by the same amount, and `res_last`=0.
- R6: A successful completion with `cpl_bytes` greater than or equal to the owed count gives `res_last`=1 and releases the slot.
- R7: A completion on a tag with an empty slot gives no result (`res_valid` stays 0) and sets `flag_unexpected`.
- R8: A request on a tag whose slot is occupied sets `flag_dup_req` and leaves that slot's address and count unchanged.
- R9: A successful completion whose `cpl_lo_addr` differs from bits [6:0] of the slot address sets `flag_mismatch`. The result is still formed as in R3.
- R10: Each flag stays set until reset.
- R11: A request and a completion in the same cycle on the same tag both act on the slot state from before that cycle. A completion on an empty slot is unexpected, and the request in the same cycle fills the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request issued this cycle |
| req_tag | input | 5 | Tag of the request |
| req_addr | input | 12 | Low 12 bits of the request byte address |
| req_bytes | input | 13 | Byte count of the request |
| cpl_valid | input | 1 | Completion beat present this cycle |
| cpl_tag | input | 5 | Tag of the completion |
| cpl_lo_addr | input | 7 | 7-bit lower address from the completion header |
| cpl_bytes | input | 13 | Bytes delivered by this completion |
| cpl_err | input | 1 | Completion reports an error status |
| res_valid | output | 1 | Result strobe |
| res_tag | output | 5 | Tag of the result |
| res_addr | output | 12 | Rebuilt lower byte address |
| res_hi_ok | output | 1 | Bits [11:7] of res_addr are meaningful |
| res_err | output | 1 | Error status passed through |
| res_last | output | 1 | The slot was released by this completion |
| flag_dup_req | output | 1 | Sticky: request issued on an occupied tag |
| flag_mismatch | output | 1 | Sticky: header low bits disagreed with the slot |
| flag_unexpected | output | 1 | Sticky: completion on an empty slot |

## Verification
Any wrong slot content shows up at the ports on the next completion for that tag, one clock after it is sampled. A stale or wrongly advanced address changes `res_addr[11:7]` and, when the header bits are copied from the expected address, it also raises `flag_mismatch`. A slot that is released too early or too late changes `res_last`, or leaves a later completion reported as a result where it should be unexpected (or the reverse). The bench sweeps all 32 tags through split reads, following each slot's address and count arithmetically from step to step.

// File: rtl/cpl_la_pkg.sv
package cpl_la_pkg;

    localparam int TAG_W  = 5;
    localparam int ADDR_W = 12;
    localparam int LO_W   = 7;
    localparam int CNT_W  = 13;
    localparam int DEPTH  = 1 << TAG_W;
    localparam int HI_W   = ADDR_W - LO_W;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  owed;
    } slot_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  bytes;
    } req_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [LO_W-1:0]  lo;
        logic [CNT_W-1:0] bytes;
        logic             err;
    } cpl_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic              hi_ok;
        logic              err;
        logic              last;
    } res_t;

    typedef struct packed {
        logic  hit;
        logic  mismatch;
        slot_t next;
        res_t  res;
    } step_t;

    // Join the trusted upper bits to the header bits; on error only header bits survive.
    function automatic logic [ADDR_W-1:0] widen_addr(
        input logic [HI_W-1:0] hi,
        input logic [LO_W-1:0] lo,
        input logic            err
    );
        logic [HI_W-1:0] upper;
        upper = err ? '0 : hi;
        return {upper, lo};
    endfunction

    // A completion closes the slot once it covers everything still owed.
    function automatic logic covers_all(
        input logic [CNT_W-1:0] delivered,
        input logic [CNT_W-1:0] owed
    );
        return delivered >= owed;
    endfunction

endpackage

// File: rtl/cpl_la_slots.sv
module cpl_la_slots
    import cpl_la_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic             cpl_we,
    input  slot_t            cpl_wdata,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_we,
    input  slot_t            req_wdata,
    output slot_t            cpl_rdata,
    output logic             req_busy
);

    slot_t slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (cpl_we && (cpl_tag == TAG_W'(i))) begin
                slot_q[i] <= cpl_wdata;
            end else if (req_we && (req_tag == TAG_W'(i))) begin
                slot_q[i] <= req_wdata;
            end
        end
    end

    always_comb begin
        cpl_rdata = slot_q[cpl_tag];
        req_busy  = slot_q[req_tag].valid;
    end

endmodule

// File: rtl/cpl_la_step.sv
module cpl_la_step
    import cpl_la_pkg::*;
(
    input  cpl_t  cpl,
    input  slot_t cur,
    output step_t step
);

    logic [HI_W-1:0] cur_hi;
    logic [LO_W-1:0] cur_lo;
    logic            done;

    always_comb begin
        cur_hi = cur.addr[ADDR_W-1:LO_W];
        cur_lo = cur.addr[LO_W-1:0];
        done   = cpl.err || covers_all(cpl.bytes, cur.owed);

        step.hit      = cur.valid;
        step.mismatch = cur.valid && !cpl.err && (cpl.lo != cur_lo);

        step.res.tag   = cpl.tag;
        step.res.addr  = widen_addr(cur_hi, cpl.lo, cpl.err);
        step.res.hi_ok = !cpl.err;
        step.res.err   = cpl.err;
        step.res.last  = done;

        if (done) begin
            step.next = '0;
        end else begin
            step.next.valid = 1'b1;
            step.next.addr  = cur.addr + cpl.bytes[ADDR_W-1:0];
            step.next.owed  = cur.owed - cpl.bytes;
        end
    end

endmodule

// File: rtl/cpl_la_flags.sv
module cpl_la_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_dup,
    input  logic set_mis,
    input  logic set_unexp,
    output logic dup_q,
    output logic mis_q,
    output logic unexp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dup_q   <= 1'b0;
            mis_q   <= 1'b0;
            unexp_q <= 1'b0;
        end else begin
            dup_q   <= dup_q   | set_dup;
            mis_q   <= mis_q   | set_mis;
            unexp_q <= unexp_q | set_unexp;
        end
    end

endmodule

// File: rtl/cpl_la_rebuild.sv
module cpl_la_rebuild
    import cpl_la_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [LO_W-1:0]   cpl_lo_addr,
    input  logic [CNT_W-1:0]  cpl_bytes,
    input  logic              cpl_err,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [ADDR_W-1:0] res_addr,
    output logic              res_hi_ok,
    output logic              res_err,
    output logic              res_last,
    output logic              flag_dup_req,
    output logic              flag_mismatch,
    output logic              flag_unexpected
);

    req_t  req_in;
    cpl_t  cpl_in;
    slot_t cur_slot;
    slot_t fill_slot;
    step_t step;
    logic  req_busy;
    logic  cpl_we;
    logic  req_we;
    res_t  res_q;
    logic  res_v_q;

    always_comb begin
        req_in.tag   = req_tag;
        req_in.addr  = req_addr;
        req_in.bytes = req_bytes;
        cpl_in.tag   = cpl_tag;
        cpl_in.lo    = cpl_lo_addr;
        cpl_in.bytes = cpl_bytes;
        cpl_in.err   = cpl_err;

        fill_slot.valid = 1'b1;
        fill_slot.addr  = req_in.addr;
        fill_slot.owed  = req_in.bytes;

        cpl_we = cpl_valid && step.hit;
        req_we = req_valid && !req_busy;
    end

    cpl_la_slots slots_i (
        .clk       (clk),
        .rst       (rst),
        .cpl_tag   (cpl_in.tag),
        .cpl_we    (cpl_we),
        .cpl_wdata (step.next),
        .req_tag   (req_in.tag),
        .req_we    (req_we),
        .req_wdata (fill_slot),
        .cpl_rdata (cur_slot),
        .req_busy  (req_busy)
    );

    cpl_la_step step_i (
        .cpl  (cpl_in),
        .cur  (cur_slot),
        .step (step)
    );

    cpl_la_flags flags_i (
        .clk       (clk),
        .rst       (rst),
        .set_dup   (req_valid && req_busy),
        .set_mis   (cpl_valid && step.mismatch),
        .set_unexp (cpl_valid && !step.hit),
        .dup_q     (flag_dup_req),
        .mis_q     (flag_mismatch),
        .unexp_q   (flag_unexpected)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_v_q <= 1'b0;
            res_q   <= '0;
        end else begin
            res_v_q <= cpl_we;
            if (cpl_we) begin
                res_q <= step.res;
            end
        end
    end

    always_comb begin
        res_valid = res_v_q;
        res_tag   = res_q.tag;
        res_addr  = res_q.addr;
        res_hi_ok = res_q.hi_ok;
        res_err   = res_q.err;
        res_last  = res_q.last;
    end

endmodule

// File: rtl/cpl_la_rebuild_chk.sv
module cpl_la_rebuild_chk
    import cpl_la_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [TAG_W-1:0]  req_tag,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CNT_W-1:0]  req_bytes,
    input logic              cpl_valid,
    input logic [TAG_W-1:0]  cpl_tag,
    input logic [LO_W-1:0]   cpl_lo_addr,
    input logic [CNT_W-1:0]  cpl_bytes,
    input logic              cpl_err,
    input logic              res_valid,
    input logic [TAG_W-1:0]  res_tag,
    input logic [ADDR_W-1:0] res_addr,
    input logic              res_hi_ok,
    input logic              res_err,
    input logic              res_last,
    input logic              flag_dup_req,
    input logic              flag_mismatch,
    input logic              flag_unexpected
);

    AST_RES_FOLLOWS_CPL: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(cpl_valid) && res_tag == $past(cpl_tag)));          // R2
    AST_LOW_FROM_HDR: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_addr[LO_W-1:0] == $past(cpl_lo_addr));                 // R3
    AST_GOOD_HI_OK: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_err) |-> res_hi_ok);                                  // R3
    AST_ERR_PASSED: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_err == $past(cpl_err));                                // R4
    AST_ERR_HI_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err) |-> (res_addr[ADDR_W-1:LO_W] == '0 && !res_hi_ok && res_last)); // R4
    AST_UNEXP_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_unexpected) |-> !res_valid);                                  // R7
    AST_DUP_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_dup_req |=> flag_dup_req);                                          // R10
    AST_MIS_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_mismatch |=> flag_mismatch);                                        // R10
    AST_UNEXP_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_unexpected |=> flag_unexpected);                                    // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && !flag_dup_req && !flag_mismatch && !flag_unexpected)); // R1

endmodule

bind cpl_la_rebuild cpl_la_rebuild_chk chk_i (.*);

// File: tb/cpl_la_rebuild_tb_top.sv
module cpl_la_rebuild_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [4:0]  req_tag = '0;
    logic [11:0] req_addr = '0;
    logic [12:0] req_bytes = '0;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_tag = '0;
    logic [6:0]  cpl_lo_addr = '0;
    logic [12:0] cpl_bytes = '0;
    logic        cpl_err = 1'b0;
    logic        res_valid, res_hi_ok, res_err, res_last;
    logic [4:0]  res_tag;
    logic [11:0] res_addr;
    logic        flag_dup_req, flag_mismatch, flag_unexpected;

    int n_checks = 0;
    int n_errors = 0;

    logic        m_valid [32];
    logic [11:0] m_addr  [32];
    logic [12:0] m_owed  [32];
    logic        m_dup, m_mis, m_unexp;

    always #10 clk = ~clk;

    cpl_la_rebuild dut_i (.*);

    task automatic chk(input string lbl, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", lbl, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 32; i++) begin
            m_valid[i] = 1'b0;
            m_addr[i]  = '0;
            m_owed[i]  = '0;
        end
        m_dup = 1'b0; m_mis = 1'b0; m_unexp = 1'b0;
    endtask

    // Drive one cycle at a falling edge, predict, and check after the next rising edge.
    task automatic step(input string lbl,
                        input logic rv, input logic [4:0] rt, input logic [11:0] ra, input logic [12:0] rb,
                        input logic cv, input logic [4:0] ct, input logic [6:0] cl, input logic [12:0] cb,
                        input logic ce);
        logic        e_v, e_last, old_busy;
        logic [11:0] e_addr;
        e_v = 1'b0; e_last = 1'b0; e_addr = '0;
        old_busy = m_valid[rt];
        req_valid = rv; req_tag = rt; req_addr = ra; req_bytes = rb;
        cpl_valid = cv; cpl_tag = ct; cpl_lo_addr = cl; cpl_bytes = cb; cpl_err = ce;
        if (cv) begin
            if (m_valid[ct]) begin
                e_v    = 1'b1;
                e_addr = ce ? {5'd0, cl} : {m_addr[ct][11:7], cl};
                e_last = ce || (cb >= m_owed[ct]);
                if (!ce && cl != m_addr[ct][6:0]) m_mis = 1'b1;
                if (e_last) m_valid[ct] = 1'b0;
                else begin
                    m_addr[ct] = m_addr[ct] + cb[11:0];
                    m_owed[ct] = m_owed[ct] - cb;
                end
            end else begin
                m_unexp = 1'b1;
            end
        end
        if (rv) begin
            if (old_busy) m_dup = 1'b1;
            else begin
                m_valid[rt] = 1'b1; m_addr[rt] = ra; m_owed[rt] = rb;
            end
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; cpl_valid = 1'b0;
        chk(lbl, "res_valid", 32'(res_valid), 32'(e_v));
        if (e_v) begin
            chk(lbl, "res_tag", 32'(res_tag), 32'(ct));
            chk(lbl, "res_addr", 32'(res_addr), 32'(e_addr));
            chk(lbl, "res_hi_ok", 32'(res_hi_ok), 32'(!ce));
            chk(lbl, "res_err", 32'(res_err), 32'(ce));
            chk(lbl, "res_last", 32'(res_last), 32'(e_last));
        end
        chk(lbl, "flag_dup_req", 32'(flag_dup_req), 32'(m_dup));
        chk(lbl, "flag_mismatch", 32'(flag_mismatch), 32'(m_mis));
        chk(lbl, "flag_unexpected", 32'(flag_unexpected), 32'(m_unexp));
    endtask

    task automatic issue(input string lbl, input logic [4:0] t, input logic [11:0] a, input logic [12:0] b);
        step(lbl, 1'b1, t, a, b, 1'b0, '0, '0, '0, 1'b0);
    endtask

    task automatic complete(input string lbl, input logic [4:0] t, input logic [6:0] lo, input logic [12:0] b, input logic e);
        step(lbl, 1'b0, '0, '0, '0, 1'b1, t, lo, b, e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk("R1", "res_valid", 32'(res_valid), 0);
        chk("R1", "flag_dup_req", 32'(flag_dup_req), 0);
        chk("R1", "flag_mismatch", 32'(flag_mismatch), 0);
        chk("R1", "flag_unexpected", 32'(flag_unexpected), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();

        // R2 R3 R5 R6: every tag, split reads in 64-byte pieces with address-derived header bits
        for (int t = 0; t < 32; t++) begin
            issue("R2", 5'(t), 12'((t * 331 + 5) % 4096), 13'(64 * (1 + t % 5)));
        end
        for (int t = 0; t < 32; t++) begin
            while (m_valid[t]) begin
                complete((m_owed[t] <= 64) ? "R6" : "R5", 5'(t), m_addr[t][6:0], 13'd64, 1'b0);
            end
        end

        // R7: completion on a released slot
        complete("R7", 5'd3, 7'h05, 13'd64, 1'b0);

        // R6: count not a multiple of the piece size; second piece over-covers
        issue("R6", 5'd11, 12'h3F0, 13'd100);
        complete("R5", 5'd11, 7'h70, 13'd64, 1'b0);
        complete("R6", 5'd11, 7'h30, 13'd64, 1'b0);

        // R5: address wraps past 4095
        issue("R5", 5'd12, 12'hFC0, 13'd128);
        complete("R5", 5'd12, 7'h40, 13'd64, 1'b0);
        complete("R5", 5'd12, 7'h00, 13'd64, 1'b0);

        // R9: wrong header bits, result still uses them
        issue("R9", 5'd7, 12'h2A5, 13'd200);
        complete("R9", 5'd7, 7'h11, 13'd64, 1'b0);
        // R4: error completion clears upper bits and releases slot
        complete("R4", 5'd7, 7'h65, 13'd8, 1'b1);
        complete("R4", 5'd7, 7'h65, 13'd8, 1'b0);
        issue("R4", 5'd8, 12'hF80, 13'd256);
        complete("R4", 5'd8, 7'h00, 13'd64, 1'b1);

        // R8: duplicate issue leaves slot untouched
        issue("R8", 5'd9, 12'h100, 13'd64);
        issue("R8", 5'd9, 12'h7A3, 13'd512);
        complete("R8", 5'd9, 7'h00, 13'd64, 1'b0);

        // R11: request and completion together on an empty slot
        step("R11", 1'b1, 5'd10, 12'h555, 13'd32, 1'b1, 5'd10, 7'h55, 13'd32, 1'b0);
        complete("R11", 5'd10, 7'h55, 13'd32, 1'b0);
        // R11: together on an occupied slot, completion releases, request is a duplicate
        issue("R11", 5'd13, 12'h880, 13'd16);
        step("R11", 1'b1, 5'd13, 12'h123, 13'd16, 1'b1, 5'd13, 7'h00, 13'd16, 1'b0);
        complete("R11", 5'd13, 7'h23, 13'd16, 1'b0);

        // R10: flags hold across idle cycles
        for (int i = 0; i < 3; i++) begin
            step("R10", 1'b0, '0, '0, '0, 1'b0, '0, '0, '0, 1'b0);
        end

        // R1: reset empties the slots
        issue("R1", 5'd0, 12'h040, 13'd64);
        do_reset();
        complete("R1", 5'd0, 7'h40, 13'd64, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule